// File: doc/BRIEF.md
# Bipolar Line Code Transmit Encoder

This block turns NRZ transmit data into bipolar positive and negative rail pulses for each channel of a T1/E1 line interface. In single-rail mode the positive data input is the only source. It is coded as plain AMI, as B8ZS (an eight-zero run is replaced) or as HDB3 (a four-zero run is replaced). A chip-wide code selection applies to every channel, and each channel can override it with its own code. In this mode a test request makes the next data mark a deliberate bipolar violation. In dual-rail mode the two input rails are already encoded and pass through unchanged.

Every channel samples its inputs on the falling edge of the transmit clock. Data leaves the block exactly eight bit periods after it was sampled, in every mode, so that a whole zero run is visible before its first bit is sent. A per-channel all-ones control sends an unbroken stream of alternating marks instead of data. A chip-wide output enable, a per-channel high-impedance control and a per-channel power-down control each silence both rails of a channel without disturbing its coder state.

Top module: `lcx_encoder`

## Requirements
- R1: In single-rail mode with AMI coding, a sampled one leaves as a pulse on one rail and a sampled zero leaves as no pulse on either rail. Successive ones alternate polarity. `line_pos_o`=1 means a positive pulse and `line_neg_o`=1 means a negative pulse. Each bit appears on the rails after the eighth falling edge that follows its sampling edge.
- R2: With B8ZS, every run of eight zeros leaves as 0,0,0,V,B,0,V,B in time order. V repeats the polarity of the pulse before it. B takes the opposite polarity of the pulse before it.
- R3: With HDB3, every run of four zeros leaves as 0,0,0,V when an odd number of marks has been sent since the last V, and as B,0,0,V when that number is even. B and all-ones marks count as marks. A V resets the count. An inserted test violation does not change the count.
- R4: The effective code of a channel is its override field when the channel's override enable is 1, and the global field otherwise. The encoding is 00 = AMI, 01 = B8ZS, 10 = HDB3, 11 = AMI.
- R5: In single-rail mode, a test request held for one cycle turns the first one sampled in that cycle or later into a pulse with the same polarity as the previous pulse. This happens exactly once. The polarity of the following marks still alternates from the pulse before the violation.
- R6: In dual-rail mode (`single_i`=0), both input rails reach the output rails unchanged, with the same eight-period latency. No substitution takes place, and test requests are ignored.
- R7: While all-ones is set, every falling edge emits a mark on the output register. Each mark has the polarity opposite to the previous pulse. Input data is ignored, and the effect begins on the first falling edge after the control is set.
- R8: A low output enable, a set high-impedance bit or a set power-down bit forces both rails of the affected channel to 0 at once, without waiting for a clock edge. The channel's coder keeps running while its output is silenced.
- R9: During reset both rails are 0, the last-pulse polarity is negative (so the first mark is positive) and the mark count is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk_i | input | 1 | Transmit clock; all state updates on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_i | input | 1 | Global output enable, active high |
| glb_code_i | input | 2 | Global line code selection |
| single_i | input | NCH | Per-channel single-rail mode (1) or dual-rail mode (0) |
| code_ovr_en_i | input | NCH | Per-channel code override enable |
| code_ovr_i | input | 2*NCH | Per-channel code override, two bits per channel |
| bpv_req_i | input | NCH | Per-channel violation insertion request |
| all_ones_i | input | NCH | Per-channel all-ones transmit |
| hiz_i | input | NCH | Per-channel output high-impedance control |
| pdn_i | input | NCH | Per-channel transmitter power-down |
| tx_pos_i | input | NCH | Positive rail data in (NRZ data in single-rail mode) |
| tx_neg_i | input | NCH | Negative rail data in (dual-rail mode only) |
| line_pos_o | output | NCH | Positive pulse rail out |
| line_neg_o | output | NCH | Negative pulse rail out |

## Verification
A wrong last-pulse polarity makes the next mark or violation leave with the wrong sign. This is visible on the rails eight periods after the bit that triggered it. A wrong mark count for HDB3 turns a 000V substitution into B00V or the reverse. That fault shows within the four output bits of the next zero run, and it also flips the sign of every following V. A stuck or lost violation request shows as a repeated or missing same-polarity pair at the next data one. The bench compares each output bit against a model that is driven purely by the coding rules.

// File: rtl/lcx_pkg.sv
package lcx_pkg;
   localparam int unsigned LCX_WIN     = 8;
   localparam int unsigned LCX_HDB_RUN = 4;

   // symbols held in the look-ahead window (single-rail mode)
   typedef enum logic [1:0] {
      SYM_ZERO = 2'd0,
      SYM_MARK = 2'd1,
      SYM_VIOL = 2'd2,
      SYM_ERR  = 2'd3
   } lcx_sym_e;

   typedef enum logic [1:0] {
      LC_AMI     = 2'd0,
      LC_B8ZS    = 2'd1,
      LC_HDB3    = 2'd2,
      LC_AMI_ALT = 2'd3
   } lcx_code_e;
endpackage

// File: rtl/lcx_window.sv
module lcx_window
   import lcx_pkg::*;
#(
   parameter int unsigned WIN = LCX_WIN,
   parameter int unsigned RUN = LCX_HDB_RUN
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] sym_i,
   input  logic       b8zs_en_i,
   input  logic       hdb3_en_i,
   input  logic       par_odd_i,
   output logic [1:0] sym_o
);
   localparam int OLD = WIN - 1;
   localparam int HV  = WIN - RUN;

   if (WIN != 8) begin : g_bad_win
      $error("lcx_window: WIN must be 8 for the B8ZS pattern");
   end
   if (RUN != 4) begin : g_bad_run
      $error("lcx_window: RUN must be 4 for HDB3");
   end

   logic [WIN-1:0][1:0] win_q;
   logic [WIN-1:0][1:0] mark;
   logic                all_zero;
   logic                tail_zero;

   always_comb begin
      all_zero  = 1'b1;
      tail_zero = 1'b1;
      for (int k = 0; k < WIN; k++) begin
         if (win_q[k] != SYM_ZERO) all_zero = 1'b0;
      end
      for (int k = HV; k < WIN; k++) begin
         if (win_q[k] != SYM_ZERO) tail_zero = 1'b0;
      end
   end

   // substitution is written into the window so later checks see it
   always_comb begin
      mark = win_q;
      if (b8zs_en_i && all_zero) begin
         mark[OLD-3] = SYM_VIOL;
         mark[OLD-4] = SYM_MARK;
         mark[OLD-6] = SYM_VIOL;
         mark[OLD-7] = SYM_MARK;
      end else if (hdb3_en_i && tail_zero) begin
         if (!par_odd_i) mark[OLD] = SYM_MARK;
         mark[HV] = SYM_VIOL;
      end
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) win_q <= '0;
      else         win_q <= {mark[WIN-2:0], sym_i};
   end

   assign sym_o = mark[OLD];

   assert_b8zs_fill_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (b8zs_en_i && all_zero) |=> (win_q[OLD-2] == SYM_VIOL && win_q[OLD-3] == SYM_MARK
                                 && win_q[OLD-5] == SYM_VIOL && win_q[OLD-6] == SYM_MARK));

   assert_hdb3_fill_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (hdb3_en_i && tail_zero && !b8zs_en_i) |=> (win_q[HV+1] == SYM_VIOL));
endmodule

// File: rtl/lcx_polarity.sv
module lcx_polarity
   import lcx_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] sym_i,
   input  logic       dual_i,
   input  logic       aos_i,
   output logic       pos_o,
   output logic       neg_o,
   output logic       par_odd_o
);
   logic last_q, last_d;   // 1: last pulse was positive
   logic par_q, par_d;
   logic pos_q, pos_d, neg_q, neg_d;

   always_comb begin
      pos_d  = 1'b0;
      neg_d  = 1'b0;
      last_d = last_q;
      par_d  = par_q;
      if (aos_i) begin
         pos_d  = ~last_q;
         neg_d  = last_q;
         last_d = ~last_q;
         par_d  = ~par_q;
      end else if (dual_i) begin
         pos_d = sym_i[1];
         neg_d = sym_i[0];
      end else begin
         case (lcx_sym_e'(sym_i))
            SYM_MARK: begin
               pos_d  = ~last_q;
               neg_d  = last_q;
               last_d = ~last_q;
               par_d  = ~par_q;
            end
            SYM_VIOL: begin
               pos_d = last_q;
               neg_d = ~last_q;
               par_d = 1'b0;
            end
            SYM_ERR: begin
               pos_d = last_q;
               neg_d = ~last_q;
            end
            default: ;
         endcase
      end
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_q <= 1'b0;
         par_q  <= 1'b0;
         pos_q  <= 1'b0;
         neg_q  <= 1'b0;
      end else begin
         last_q <= last_d;
         par_q  <= par_d;
         pos_q  <= pos_d;
         neg_q  <= neg_d;
      end
   end

   assign pos_o     = pos_q;
   assign neg_o     = neg_q;
   assign par_odd_o = par_q;

   assert_zero_quiet_R1: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!dual_i && !aos_i && sym_i == SYM_ZERO) |=> (!pos_q && !neg_q));

   assert_mark_flips_R1: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!dual_i && !aos_i && sym_i == SYM_MARK) |=> (pos_q != neg_q && pos_q != $past(last_q)));

   assert_viol_repeats_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!dual_i && !aos_i && (sym_i == SYM_VIOL || sym_i == SYM_ERR))
      |=> (pos_q != neg_q && pos_q == $past(last_q)));

   assert_all_ones_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
      aos_i |=> (pos_q != neg_q && pos_q != $past(last_q)));
endmodule

// File: rtl/lcx_channel.sv
module lcx_channel
   import lcx_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       single_i,
   input  logic [1:0] code_i,
   input  logic       bpv_i,
   input  logic       aos_i,
   input  logic       dpos_i,
   input  logic       dneg_i,
   output logic       pos_o,
   output logic       neg_o
);
   logic       pend_q;
   logic [1:0] sym_in;
   logic [1:0] sym_out;
   logic       par_odd;
   logic       b8zs_en, hdb3_en;
   logic       viol_now;

   assign viol_now = pend_q | bpv_i;
   assign b8zs_en  = single_i && (code_i == LC_B8ZS);
   assign hdb3_en  = single_i && (code_i == LC_HDB3);

   always_comb begin
      if (!single_i)      sym_in = {dpos_i, dneg_i};
      else if (!dpos_i)   sym_in = SYM_ZERO;
      else if (viol_now)  sym_in = SYM_ERR;
      else                sym_in = SYM_MARK;
   end

   // request waits for the next data one; dual-rail mode drops it
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= single_i & viol_now & ~dpos_i;
   end

   lcx_window u_win (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sym_i     (sym_in),
      .b8zs_en_i (b8zs_en),
      .hdb3_en_i (hdb3_en),
      .par_odd_i (par_odd),
      .sym_o     (sym_out)
   );

   lcx_polarity u_pol (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sym_i     (sym_out),
      .dual_i    (~single_i),
      .aos_i     (aos_i),
      .pos_o     (pos_o),
      .neg_o     (neg_o),
      .par_odd_o (par_odd)
   );

   assert_dual_drops_bpv_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!single_i) |=> !pend_q);

   assert_bpv_used_once_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (pend_q && single_i && dpos_i) |=> !pend_q);
endmodule

// File: rtl/lcx_encoder.sv
module lcx_encoder
   import lcx_pkg::*;
#(
   parameter int unsigned NCH = 2
) (
   input  logic             tclk_i,
   input  logic             rst_ni,
   input  logic             oe_i,
   input  logic [1:0]       glb_code_i,
   input  logic [NCH-1:0]   single_i,
   input  logic [NCH-1:0]   code_ovr_en_i,
   input  logic [2*NCH-1:0] code_ovr_i,
   input  logic [NCH-1:0]   bpv_req_i,
   input  logic [NCH-1:0]   all_ones_i,
   input  logic [NCH-1:0]   hiz_i,
   input  logic [NCH-1:0]   pdn_i,
   input  logic [NCH-1:0]   tx_pos_i,
   input  logic [NCH-1:0]   tx_neg_i,
   output logic [NCH-1:0]   line_pos_o,
   output logic [NCH-1:0]   line_neg_o
);
   localparam int unsigned CW = $bits(lcx_code_e);

   if (NCH < 1) begin : g_bad_nch
      $error("lcx_encoder: NCH must be at least 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CW-1:0] code_eff;
      logic          pos_raw, neg_raw;
      logic          mute;

      assign code_eff = code_ovr_en_i[c] ? code_ovr_i[CW*c +: CW] : glb_code_i;
      assign mute     = ~oe_i | hiz_i[c] | pdn_i[c];

      lcx_channel u_chan (
         .clk_i    (tclk_i),
         .rst_ni   (rst_ni),
         .single_i (single_i[c]),
         .code_i   (code_eff),
         .bpv_i    (bpv_req_i[c]),
         .aos_i    (all_ones_i[c]),
         .dpos_i   (tx_pos_i[c]),
         .dneg_i   (tx_neg_i[c]),
         .pos_o    (pos_raw),
         .neg_o    (neg_raw)
      );

      assign line_pos_o[c] = pos_raw & ~mute;
      assign line_neg_o[c] = neg_raw & ~mute;
   end
endmodule

// File: tb/lcx_encoder_tb.sv
`timescale 1ns/1ps
module lcx_encoder_tb;
   localparam int NCH = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             oe = 1'b1;
   logic [1:0]       glb_code = 2'd0;
   logic [NCH-1:0]   single = '1;
   logic [NCH-1:0]   ovr_en = '0;
   logic [2*NCH-1:0] ovr_code = '0;
   logic [NCH-1:0]   bpv = '0;
   logic [NCH-1:0]   aos = '0;
   logic [NCH-1:0]   hiz = '0;
   logic [NCH-1:0]   pdn = '0;
   logic [NCH-1:0]   tx_pos = '0;
   logic [NCH-1:0]   tx_neg = '0;
   logic [NCH-1:0]   line_pos;
   logic [NCH-1:0]   line_neg;

   always #2.5 clk = ~clk;

   lcx_encoder #(.NCH(NCH)) u_dut (
      .tclk_i        (clk),
      .rst_ni        (rst_n),
      .oe_i          (oe),
      .glb_code_i    (glb_code),
      .single_i      (single),
      .code_ovr_en_i (ovr_en),
      .code_ovr_i    (ovr_code),
      .bpv_req_i     (bpv),
      .all_ones_i    (aos),
      .hiz_i         (hiz),
      .pdn_i         (pdn),
      .tx_pos_i      (tx_pos),
      .tx_neg_i      (tx_neg),
      .line_pos_o    (line_pos),
      .line_neg_o    (line_neg)
   );

   int cyc = 0;
   always @(negedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      int         due;
      int         ch;
      logic [1:0] exp;
      int         req;
   } item_t;
   item_t sb_q[$];

   logic [1:0] ex [0:95];

   task automatic check(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic logic [1:0] pol(input bit p);
      return p ? 2'b10 : 2'b01;
   endfunction

   // monitor: pops expected rail pairs as they fall due
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            logic [1:0] act;
            it  = sb_q.pop_front();
            act = {line_pos[it.ch], line_neg[it.ch]};
            check(act == it.exp && it.due == cyc, $sformatf("R%0d", it.req), act, it.exp);
         end
      end
   end

   // reference coder built from the coding rules
   task automatic encode(input int code, input logic [63:0] b, input logic [63:0] e, input int len);
      bit   bits [0:95];
      bit   errs [0:95];
      bit   last = 1'b0;
      bit   par  = 1'b0;
      bit   pend = 1'b0;
      int   n = len + 16;
      int   i = 0;
      for (int k = 0; k < 96; k++) begin
         bits[k] = (k < len) ? b[k] : 1'b0;
         errs[k] = (k < len) ? e[k] : 1'b0;
         ex[k]   = 2'b00;
      end
      while (i < n) begin
         bit run8 = 1'b1;
         bit run4 = 1'b1;
         for (int j = 0; j < 8; j++) if (i + j >= n || bits[i+j]) run8 = 1'b0;
         for (int j = 0; j < 4; j++) if (i + j >= n || bits[i+j]) run4 = 1'b0;
         if (code == 1 && run8) begin
            for (int j = 0; j < 8; j++) pend |= errs[i+j];
            ex[i+3] = pol(last);
            ex[i+4] = pol(!last); last = !last; par = !par;
            ex[i+6] = pol(last);
            ex[i+7] = pol(!last); last = !last; par = !par;
            i += 8;
         end else if (code == 2 && run4) begin
            for (int j = 0; j < 4; j++) pend |= errs[i+j];
            if (!par) begin
               ex[i] = pol(!last); last = !last;
            end
            ex[i+3] = pol(last);
            par = 1'b0;
            i += 4;
         end else begin
            pend |= errs[i];
            if (bits[i]) begin
               if (pend) begin
                  ex[i] = pol(last); pend = 1'b0;
               end else begin
                  ex[i] = pol(!last); last = !last; par = !par;
               end
            end
            i++;
         end
      end
   endtask

   // driver: single-rail stream on one channel, pushes expected items
   task automatic run_single(input int ch, input int code, input logic [63:0] b,
                             input logic [63:0] e, input int len, input int req);
      encode(code, b, e, len);
      for (int k = 0; k < len + 16; k++) begin
         item_t it;
         @(posedge clk);
         tx_pos[ch] = (k < len) ? b[k] : 1'b0;
         tx_neg[ch] = 1'b0;
         bpv[ch]    = (k < len) ? e[k] : 1'b0;
         if (k < len) begin
            it.due = cyc + 9; it.ch = ch; it.exp = ex[k]; it.req = req;
            sb_q.push_back(it);
         end
      end
      @(posedge clk);
      tx_pos[ch] = 1'b0;
      bpv[ch]    = 1'b0;
      repeat (12) @(posedge clk);
   endtask

   task automatic run_dual(input int ch, input logic [63:0] p, input logic [63:0] m,
                           input int len, input int req);
      for (int k = 0; k < len; k++) begin
         item_t it;
         @(posedge clk);
         tx_pos[ch] = p[k];
         tx_neg[ch] = m[k];
         bpv[ch]    = 1'b1;
         it.due = cyc + 9; it.ch = ch; it.exp = {p[k], m[k]}; it.req = req;
         sb_q.push_back(it);
      end
      @(posedge clk);
      tx_pos[ch] = 1'b0;
      tx_neg[ch] = 1'b0;
      bpv[ch]    = 1'b0;
      repeat (12) @(posedge clk);
   endtask

   task automatic do_reset();
      @(posedge clk);
      rst_n  = 1'b0;
      oe     = 1'b1;
      single = '1;
      ovr_en = '0;
      aos    = '0;
      hiz    = '0;
      pdn    = '0;
      tx_pos = '0;
      tx_neg = '0;
      bpv    = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

   initial begin
      int c0;
      logic [1:0] act;
      // R9: rails silent in reset
      repeat (3) @(posedge clk);
      #1;
      for (int c = 0; c < NCH; c++) begin
         act = {line_pos[c], line_neg[c]};
         check(act == 2'b00, "R9 reset", act, 2'b00);
      end
      rst_n = 1'b1;

      // R1: AMI, alternating marks, eight-period latency
      glb_code = 2'd0;
      run_single(0, 0, 64'h0000_00A0_1E00_D3B5, 64'h0, 40, 1);

      // R2: B8ZS with single and double zero runs
      do_reset(); glb_code = 2'd1;
      run_single(0, 1, 64'h0000_0000_8100_4007, 64'h0, 48, 2);
      do_reset(); glb_code = 2'd1;
      run_single(0, 1, 64'h0000_0012_0040_0C01, 64'h0, 48, 2);

      // R3: HDB3 with odd and even mark counts before zero runs
      do_reset(); glb_code = 2'd2;
      run_single(0, 2, 64'h0000_0000_8100_4007, 64'h0, 48, 3);
      do_reset(); glb_code = 2'd2;
      run_single(0, 2, 64'h0000_0041_0C21_0B07, 64'h0, 48, 3);

      // R4: code 11 acts as AMI; per-channel override beats global
      do_reset(); glb_code = 2'd3;
      run_single(0, 0, 64'h0000_0000_0100_0003, 64'h0, 32, 4);
      do_reset(); glb_code = 2'd1; ovr_en[1] = 1'b1; ovr_code[3:2] = 2'b10;
      run_single(1, 2, 64'h0000_0000_8100_4007, 64'h0, 48, 4);
      ovr_en = '0;

      // R5: violation on a one, and a request on a zero waiting for the next one
      do_reset(); glb_code = 2'd0;
      run_single(0, 0, 64'h0000_0000_0000_0F0F, 64'h0000_0000_0000_0084, 24, 5);
      do_reset(); glb_code = 2'd2;
      run_single(0, 2, 64'h0000_0000_8100_4007, 64'h0000_0000_0000_4002, 48, 5);

      // R6: dual-rail pass-through with requests held high
      do_reset(); glb_code = 2'd1; single[0] = 1'b0;
      run_dual(0, 64'h0000_0000_0000_0013, 64'h0000_0000_0000_0C40, 24, 6);

      // R7: all-ones marks, first positive after reset
      do_reset(); glb_code = 2'd0;
      @(posedge clk);
      aos[0] = 1'b1;
      c0 = cyc;
      repeat (5) begin
         @(posedge clk);
         #1;
         act = {line_pos[0], line_neg[0]};
         check(act == pol(((cyc - c0) % 2) == 1), "R7 all-ones", act, pol(((cyc - c0) % 2) == 1));
      end

      // R8: each silencing control, then coder found still running
      @(posedge clk); oe = 1'b0; #1;
      for (int c = 0; c < NCH; c++) begin
         act = {line_pos[c], line_neg[c]};
         check(act == 2'b00, "R8 output enable", act, 2'b00);
      end
      @(posedge clk); oe = 1'b1; hiz[0] = 1'b1; #1;
      act = {line_pos[0], line_neg[0]};
      check(act == 2'b00, "R8 high-impedance", act, 2'b00);
      @(posedge clk); hiz[0] = 1'b0; pdn[0] = 1'b1; #1;
      act = {line_pos[0], line_neg[0]};
      check(act == 2'b00, "R8 power-down", act, 2'b00);
      @(posedge clk); pdn[0] = 1'b0; #1;
      act = {line_pos[0], line_neg[0]};
      check(act == pol(((cyc - c0) % 2) == 1), "R8 state kept", act, pol(((cyc - c0) % 2) == 1));
      aos[0] = 1'b0;

      repeat (20) @(posedge clk);
      if (sb_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL scoreboard actual=%0d expected=0 items left", sb_q.size());
      end
      finish_up();
   end
endmodule